// File: doc/BRIEF.md
# Motor-Control PWM Enable and Reload Controller

This block drives three complementary output pairs (six pins) for a motor inverter. One up-counting time base is compared against six duty values. A small write port programs the block. Modulus, prescaler and duty values are written into shadow copies. The shadow copies move into the working copies only at a reload event, and only while a load-permit bit is set. Each pair can run in complementary mode. In that mode both sides of a pair are held low for a programmed dead time after every change, so the upper and lower switches never conduct together. Each pin can instead run on its own without dead time.

The enable bit sets the order of events at start-up and shut-down. Turning it on forces an immediate reload, which raises the reload flag and, if allowed, the interrupt. Turning it off stops and clears the counter and pulls the generator's drives low. The fault path, manual pin control and dead-time logic keep working while the block is disabled. A fault input forces every pin to its inactive level at once. A current-sense select input makes each pair alternate between its two duty slots on successive periods.

Write map (4-bit address): 0 control, 1 modulus shadow, 2 prescaler shadow (2 bits), 3 dead time (8 bits, in clocks), 4 manual pin values (6 bits), 5 polarity (6 bits), 8 to 13 duty-value shadows for slots 0 to 5.

Control bits at address 0:

| Bit | Function |
|-----|----------|
| 0 | enable |
| 1 | load-permit |
| 2 | interrupt enable |
| 3 | write 1 to clear the reload flag |
| 4 | manual output control |
| 5 | complementary mode |

Top module: `mcpwm_ctrl`

## Requirements
- R1: After reset the block is disabled. All output enables are 0 and irq is 0. With polarity 0, every pin value is 0.
- R2: Setting the enable bit (control bit 0) causes a reload at the second clock edge after the write cycle. The reload sets the reload flag, and irq (flag AND control bit 2) goes high. If load-permit (control bit 1) is 1 at that reload, the shadow modulus, prescaler and duty values become active and load-permit clears. Shadow writes made without load-permit leave the running period and duties unchanged.
- R3: If the block is enabled after reset without load-permit, the active prescaler and duty values are 0, so every generated drive stays 0. If it is disabled and re-enabled without load-permit, the modulus last made active stays in use.
- R4: The counter starts at 1 on the enable reload. It advances once every 2^P clocks, where P is the active prescaler. It wraps from the modulus back to 1, and each wrap is a reload. In independent mode (control bit 5 = 0), pin i is high while 1 <= count <= duty slot i.
- R5: In complementary mode, pair k wants pin 2k high while 1 <= count <= its duty, and pin 2k+1 is the opposite. After every change of that want, both pins are low for D clocks, where D is the dead-time register. D = 0 gives no gap. A dead-time change during a gap never makes the gap shorter than the value in force.
- R6: In complementary mode with the current-sense input high, pair k uses duty slot 2k and slot 2k+1 on alternate periods. The first period after enable uses slot 2k.
- R7: While enable is 0, the counter is held at 0 and the generated drives are 0. The output enables are 0 unless manual control (control bit 4) is 1, in which case they are all 1.
- R8: With manual control set, the drives come from the manual register (address 4), whether enable is set or clear. In complementary mode, bit 2k sets pair k's want and passes through the dead-time logic. In independent mode, bit i drives pin i.
- R9: The reload flag and irq stay set when enable is cleared. Only writing 1 to control bit 3 clears the flag.
- R10: Pin i equals drive i XOR polarity bit i. While the fault input is high, every pin shows its polarity bit (its inactive level) in the same cycle, overriding both generated and manual drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | CW (16) | Register write data |
| fault_in | input | 1 | Fault; forces pins inactive while high |
| isense_sel | input | 1 | Current-sense select (duty slot alternation) |
| pwm_out | output | 2*NPAIR (6) | Pin drive values |
| pwm_oe | output | 2*NPAIR (6) | Pin output enables |
| irq | output | 1 | Reload interrupt |

## Verification
A register write becomes visible in internal state at the next clock edge. The enable reload, flag and irq follow one edge after that. Count, duty compare and dead-time effects show on the pins in the cycle after the edge that changed them. The fault override and the output-enable response to control state act within the same cycle. The bench drives inputs on the falling edge. Late in every cycle, it compares pins, enables and irq against a behavioural model stepped on each rising edge, so each result is checked in exactly the cycle it is due. Directed checks add the reset state, the flag surviving a disable and the fault override.

// File: rtl/mcpwm_pkg.sv
`timescale 1ns/1ps
// Shared constants for the motor-control PWM controller: write map
// addresses and control-register bit positions.
package mcpwm_pkg;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_MOD  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PRE  = 4'd2;
    localparam logic [ADDR_W-1:0] A_DEAD = 4'd3;
    localparam logic [ADDR_W-1:0] A_MAN  = 4'd4;
    localparam logic [ADDR_W-1:0] A_POL  = 4'd5;
    localparam logic [ADDR_W-1:0] A_VAL0 = 4'd8;

    localparam int C_EN   = 0;
    localparam int C_LOK  = 1;
    localparam int C_IEN  = 2;
    localparam int C_FCLR = 3;
    localparam int C_MAN  = 4;
    localparam int C_COMP = 5;
endpackage

// File: rtl/mcpwm_timebase.sv
`timescale 1ns/1ps
// Time base: prescaled up-counter with an equality wrap.
// Assumes modulus != 0 (an equality compare never matches 0 in a
// normal run). Cleared and frozen while en is low. On the first
// enabled cycle it raises start and loads 1. On a prescaler tick
// with count == modulus it raises wrap and loads 1.
module mcpwm_timebase #(
    parameter int CW = 16,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] modulus,
    input  logic [PW-1:0] presc,
    output logic [CW-1:0] cnt,
    output logic          start,
    output logic          wrap
);
    localparam int PCW = (1 << PW) - 1;

    logic           en_d;
    logic [PCW-1:0] pc;
    logic [PCW-1:0] lim;
    logic           tick;

    // Prescaler limit and tick decode.
    always_comb begin
        lim   = (PCW'(1) << presc) - PCW'(1);
        tick  = (pc == lim);
        start = en && !en_d;
        wrap  = en && en_d && tick && (cnt == modulus);
    end

    // Count sequencing: idle clear, enable start, tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d <= 1'b0;
            cnt  <= '0;
            pc   <= '0;
        end else begin
            en_d <= en;
            if (!en) begin
                cnt <= '0;
                pc  <= '0;
            end else if (!en_d) begin
                cnt <= CW'(1);
                pc  <= '0;
            end else if (tick) begin
                pc  <= '0;
                cnt <= (cnt == modulus) ? CW'(1) : cnt + CW'(1);
            end else begin
                pc <= pc + PCW'(1);
            end
        end
    end
endmodule

// File: rtl/mcpwm_deadtime.sv
`timescale 1ns/1ps
// Dead-time inserter for one complementary pair. Each change of want
// blanks both sides for `dead` clocks, counted from the change with a
// saturating age counter, so raising or lowering `dead` mid-gap never
// ends a gap before the value now programmed.
module mcpwm_deadtime #(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           want,
    input  logic [DTW-1:0] dead,
    output logic           hi,
    output logic           lo
);
    logic           prev;
    logic [DTW-1:0] age;
    logic           gap;

    // Blanking decode and pair drive.
    always_comb begin
        gap = (want != prev) ? (dead != '0) : (age < dead);
        hi  = !gap && want;
        lo  = !gap && !want;
    end

    // Track the last want and the clocks elapsed since it changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            age  <= '1;
        end else begin
            prev <= want;
            if (want != prev) begin
                age <= DTW'(1);
            end else if (age != '1) begin
                age <= age + DTW'(1);
            end
        end
    end
endmodule

// File: rtl/mcpwm_ctrl.sv
`timescale 1ns/1ps
// Motor-control PWM controller top. Holds the write-port registers,
// shadow and active copies of modulus, prescaler and duties, the reload
// flag and the enable sequencing. Builds per-pin compares, per-pair
// dead time and the fault/polarity output stage.
// Assumes CW >= 2*NPAIR, CW >= DTW, CW >= 6 and NPAIR <= 4.
module mcpwm_ctrl
    import mcpwm_pkg::*;
#(
    parameter int CW    = 16,
    parameter int DTW   = 8,
    parameter int PW    = 2,
    parameter int NPAIR = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CW-1:0]        wr_data,
    input  logic                 fault_in,
    input  logic                 isense_sel,
    output logic [2*NPAIR-1:0]   pwm_out,
    output logic [2*NPAIR-1:0]   pwm_oe,
    output logic                 irq
);
    localparam int NOUT = 2 * NPAIR;

    logic            en_q, lok_q, ien_q, outc_q, comp_q, flag_q, ph_q;
    logic [CW-1:0]   mod_buf, mod_act;
    logic [PW-1:0]   pre_buf, pre_act;
    logic [DTW-1:0]  dead_q;
    logic [NOUT-1:0] man_q, pol_q;
    logic [CW-1:0]   val_buf [NOUT];
    logic [CW-1:0]   val_act [NOUT];
    logic [CW-1:0]   cnt;
    logic            start, wrap, reload, wr_ctrl;
    logic [NOUT-1:0] comp_drv, ind_drv, drive;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign reload  = start | wrap;

    // Control bits, load-permit self-clear and sticky reload flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lok_q  <= 1'b0;
            ien_q  <= 1'b0;
            outc_q <= 1'b0;
            comp_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= wr_data[C_EN];
                ien_q  <= wr_data[C_IEN];
                outc_q <= wr_data[C_MAN];
                comp_q <= wr_data[C_COMP];
            end
            if (wr_ctrl) lok_q <= wr_data[C_LOK];
            else if (reload) lok_q <= 1'b0;
            if (reload) flag_q <= 1'b1;
            else if (wr_ctrl && wr_data[C_FCLR]) flag_q <= 1'b0;
        end
    end

    // Shadow registers, active transfer and current-sense phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_buf <= '0;
            pre_buf <= '0;
            dead_q  <= '0;
            man_q   <= '0;
            pol_q   <= '0;
            pre_act <= '0;
            ph_q    <= 1'b0;
            for (int i = 0; i < NOUT; i++) begin
                val_buf[i] <= '0;
                val_act[i] <= '0;
            end
        end else begin
            if (wr_en && wr_addr == A_MOD)  mod_buf <= wr_data;
            if (wr_en && wr_addr == A_PRE)  pre_buf <= wr_data[PW-1:0];
            if (wr_en && wr_addr == A_DEAD) dead_q  <= wr_data[DTW-1:0];
            if (wr_en && wr_addr == A_MAN)  man_q   <= wr_data[NOUT-1:0];
            if (wr_en && wr_addr == A_POL)  pol_q   <= wr_data[NOUT-1:0];
            for (int i = 0; i < NOUT; i++) begin
                if (wr_en && wr_addr == A_VAL0 + ADDR_W'(i)) val_buf[i] <= wr_data;
            end
            if (reload && lok_q) begin
                pre_act <= pre_buf;
                for (int i = 0; i < NOUT; i++) val_act[i] <= val_buf[i];
            end
            if (start) ph_q <= 1'b0;
            else if (wrap) ph_q <= ~ph_q;
        end
    end

    // Active modulus: deliberately without reset, keeps its last load.
    always_ff @(posedge clk) begin
        if (reload && lok_q) mod_act <= mod_buf;
    end

    mcpwm_timebase #(.CW(CW), .PW(PW)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .modulus (mod_act),
        .presc   (pre_act),
        .cnt     (cnt),
        .start   (start),
        .wrap    (wrap)
    );

    // Complementary pairs: duty slot select, compare, dead time (R5, R6).
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        logic [CW-1:0] duty;
        logic          want, hi, lo;
        assign duty = (isense_sel && ph_q) ? val_act[2*k+1] : val_act[2*k];
        assign want = outc_q ? man_q[2*k]
                             : (en_q && cnt != '0 && cnt <= duty);
        mcpwm_deadtime #(.DTW(DTW)) u_dt (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want),
            .dead  (dead_q),
            .hi    (hi),
            .lo    (lo)
        );
        assign comp_drv[2*k]   = hi;
        assign comp_drv[2*k+1] = lo;
    end

    // Independent pins: one compare per duty slot (R4, R8).
    for (genvar i = 0; i < NOUT; i++) begin : g_ind
        assign ind_drv[i] = outc_q ? man_q[i]
                                   : (en_q && cnt != '0 && cnt <= val_act[i]);
    end

    // Output stage: idle forcing, polarity, fault override (R7, R10).
    always_comb begin
        if (comp_q) drive = (en_q || outc_q) ? comp_drv : '0;
        else        drive = ind_drv;
        pwm_out = fault_in ? pol_q : (drive ^ pol_q);
        pwm_oe  = {NOUT{en_q | outc_q}};
        irq     = flag_q & ien_q;
    end
endmodule

// File: rtl/mcpwm_chk.sv
`timescale 1ns/1ps
// Protocol checker for mcpwm_ctrl, attached by bind. Observes control
// state, the time base and the pins. Drives nothing.
module mcpwm_chk #(
    parameter int CW   = 16,
    parameter int NOUT = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            flag,
    input logic            lok,
    input logic            reload,
    input logic            wr_ctrl,
    input logic            clr_bit,
    input logic [CW-1:0]   cnt,
    input logic            fault_in,
    input logic [NOUT-1:0] pwm_out,
    input logic [NOUT-1:0] pol
);
    // R2
    enable_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> flag);

    // R2
    lok_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && lok && !wr_ctrl) |=> !lok);

    // R7
    idle_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_ctrl && clr_bit)) |=> flag);

    // R10
    fault_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |-> (pwm_out == pol));
endmodule

bind mcpwm_ctrl mcpwm_chk #(.CW(CW), .NOUT(2*NPAIR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .flag     (flag_q),
    .lok      (lok_q),
    .reload   (reload),
    .wr_ctrl  (wr_ctrl),
    .clr_bit  (wr_data[mcpwm_pkg::C_FCLR]),
    .cnt      (cnt),
    .fault_in (fault_in),
    .pwm_out  (pwm_out),
    .pol      (pol_q)
);

// File: tb/test_mcpwm_ctrl.sv
`timescale 1ns/100ps
// Bench for mcpwm_ctrl: behavioural per-cycle model compared every clock,
// plus directed checks.
module test_mcpwm_ctrl;
    localparam int EN = 1, LOK = 2, IEN = 4, FCLR = 8, MAN = 16, COMP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_in = 1'b0;
    logic        isense_sel = 1'b0;
    logic [5:0]  pwm_out, pwm_oe;
    logic        irq;

    int    n_run = 0, n_fail = 0;
    string cur_req = "R1";
    bit    cmp_on = 0;

    // model state
    int m_en, m_end, m_lok, m_ien, m_flag, m_outc, m_comp;
    int m_mb, m_pb, m_dead, m_man, m_pol, m_ma, m_pa, m_cnt, m_pc, m_ph;
    int vb[6], va[6], prv[3], age[3];

    mcpwm_ctrl i_mcpwm_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_in(fault_in), .isense_sel(isense_sel),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic int m_want(int k);
        int d;
        if (m_outc != 0) return (m_man >> (2*k)) & 1;
        d = (isense_sel && m_ph != 0) ? va[2*k+1] : va[2*k];
        return (m_en != 0 && m_cnt != 0 && m_cnt <= d) ? 1 : 0;
    endfunction

    function automatic logic [5:0] m_pins();
        logic [5:0] drv;
        for (int k = 0; k < 3; k++) begin
            int w = m_want(k);
            bit gap = (w != prv[k]) ? (m_dead != 0) : (age[k] < m_dead);
            drv[2*k]   = !gap && (w == 1);
            drv[2*k+1] = !gap && (w == 0);
        end
        if (m_comp != 0) begin
            if (m_en == 0 && m_outc == 0) drv = '0;
        end else begin
            for (int i = 0; i < 6; i++)
                drv[i] = (m_outc != 0) ? m_man[i]
                         : (m_en != 0 && m_cnt != 0 && m_cnt <= va[i]);
        end
        return fault_in ? 6'(m_pol) : (drv ^ 6'(m_pol));
    endfunction

    // Model step on each rising edge, from pre-edge state and inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_end = 0; m_lok = 0; m_ien = 0; m_flag = 0; m_outc = 0;
            m_comp = 0; m_mb = 0; m_pb = 0; m_dead = 0; m_man = 0; m_pol = 0;
            m_pa = 0; m_cnt = 0; m_pc = 0; m_ph = 0;
            for (int i = 0; i < 6; i++) begin vb[i] = 0; va[i] = 0; end
            for (int k = 0; k < 3; k++) begin prv[k] = 0; age[k] = 255; end
        end else begin
            bit start, tick, wrp, rld, wc;
            int wv[3];
            for (int k = 0; k < 3; k++) wv[k] = m_want(k);
            start = m_en != 0 && m_end == 0;
            tick  = m_pc == (1 << m_pa) - 1;
            wrp   = m_en != 0 && m_end != 0 && tick && m_cnt == m_ma;
            rld   = start || wrp;
            wc    = wr_en && wr_addr == 0;
            for (int k = 0; k < 3; k++) begin
                if (wv[k] != prv[k]) age[k] = 1;
                else if (age[k] < 255) age[k]++;
                prv[k] = wv[k];
            end
            if (m_en == 0) begin m_cnt = 0; m_pc = 0; end
            else if (m_end == 0) begin m_cnt = 1; m_pc = 0; end
            else if (tick) begin m_pc = 0; m_cnt = (m_cnt == m_ma) ? 1 : (m_cnt + 1) % 65536; end
            else m_pc++;
            m_end = m_en;
            if (start) m_ph = 0; else if (wrp) m_ph = 1 - m_ph;
            if (rld && m_lok != 0) begin
                m_ma = m_mb; m_pa = m_pb;
                for (int i = 0; i < 6; i++) va[i] = vb[i];
            end
            if (wc) m_lok = wr_data[1]; else if (rld) m_lok = 0;
            if (rld) m_flag = 1; else if (wc && wr_data[3]) m_flag = 0;
            if (wc) begin
                m_en = wr_data[0]; m_ien = wr_data[2]; m_outc = wr_data[4]; m_comp = wr_data[5];
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd1: m_mb = wr_data;
                    4'd2: m_pb = wr_data[1:0];
                    4'd3: m_dead = wr_data[7:0];
                    4'd4: m_man = wr_data[5:0];
                    4'd5: m_pol = wr_data[5:0];
                    default: if (wr_addr >= 8 && wr_addr <= 13) vb[wr_addr-8] = wr_data;
                endcase
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison late in each cycle.
    always @(negedge clk) begin
        #1.5;
        if (cmp_on) begin
            chk(cur_req, "pwm_out", pwm_out, m_pins());
            chk(cur_req, "pwm_oe", pwm_oe, (m_en != 0 || m_outc != 0) ? 6'h3f : 6'h00);
            chk(cur_req, "irq", irq, (m_flag != 0 && m_ien != 0) ? 1 : 0);
        end
    end

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        #1;
        cur_req = "R1";
        chk("R1", "reset oe", pwm_oe, 0);
        chk("R1", "reset irq", irq, 0);
        chk("R1", "reset pins", pwm_out, 0);
        @(negedge clk);

        // R3: enable with nothing loaded, shadows non-zero
        cur_req = "R3";
        wr(1, 9); wr(2, 1);
        for (int i = 0; i < 6; i++) wr(8 + i, 5);
        wr(0, EN);
        run(12);
        chk("R3", "unloaded pins", pwm_out, 0);
        wr(0, 0);
        wr(0, FCLR);
        run(3);

        // R4 / R2: independent mode, load and run
        cur_req = "R4";
        wr(1, 10); wr(2, 0);
        wr(8, 3); wr(9, 5); wr(10, 0); wr(11, 10); wr(12, 12); wr(13, 7);
        wr(0, EN | LOK | IEN);
        #1 chk("R2", "irq before reload", irq, 0);
        @(negedge clk);
        #1 chk("R2", "irq after reload", irq, 1);
        run(40);

        cur_req = "R9";
        wr(0, EN | IEN | FCLR);
        run(5);

        // R2: shadow write without load-permit, then with
        cur_req = "R2";
        wr(1, 6);
        run(30);
        wr(0, EN | LOK | IEN);
        run(30);

        cur_req = "R4";
        wr(2, 2); wr(0, EN | LOK | IEN);
        run(70);

        // R9 / R7: disable keeps flag
        cur_req = "R7";
        wr(0, IEN);
        #1;
        chk("R7", "oe after disable", pwm_oe, 0);
        chk("R9", "irq kept after disable", irq, 1);
        run(10);

        // R3: re-enable without load-permit keeps modulus 6
        cur_req = "R3";
        wr(1, 4);
        wr(0, EN | IEN);
        run(60);

        // R5: complementary with dead time
        cur_req = "R5";
        wr(0, 0); wr(0, FCLR);
        wr(1, 12); wr(2, 0); wr(3, 2);
        wr(8, 4); wr(9, 9); wr(10, 7); wr(11, 2); wr(12, 0); wr(13, 11);
        wr(0, EN | LOK | COMP);
        run(50);
        wr(3, 5);
        run(40);
        wr(3, 0);
        run(30);

        // R6: current-sense alternation
        cur_req = "R6";
        isense_sel = 1'b1;
        wr(3, 1);
        wr(0, COMP);
        wr(0, EN | LOK | COMP);
        run(60);
        isense_sel = 1'b0;

        // R8: manual control, enabled and disabled, both modes
        cur_req = "R8";
        wr(4, 6'b000101);
        wr(0, EN | MAN | COMP);
        run(10);
        wr(0, MAN | COMP);
        wr(4, 6'b010000);
        run(10);
        wr(4, 6'b000001);
        run(10);
        wr(0, MAN);
        wr(4, 6'b101010);
        run(5);

        // R10: polarity and fault override
        cur_req = "R10";
        wr(5, 6'b100101);
        run(3);
        fault_in = 1'b1;
        #1 chk("R10", "fault manual", pwm_out, 6'b100101);
        run(3);
        fault_in = 1'b0;
        wr(0, EN | LOK | COMP);
        run(20);
        fault_in = 1'b1;
        #1 chk("R10", "fault pwm", pwm_out, 6'b100101);
        run(3);
        fault_in = 1'b0;
        run(20);

        cmp_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule